// File: doc/BRIEF.md
# Programmable IR Pulse Symbol Decoder

This block turns the output of an infrared demodulator into received data words. The input is resynchronised to the system clock and sampled on every tick of a slow IR clock enable. For each symbol it counts two things in IR ticks: the width of the mark (the active pulse) and the period from the start of that mark to the start of the next mark. The first symbol of a frame can be required to be a leader. Each later symbol is compared against four programmable data windows and yields one bit. The bit is placed into a 64-bit receive register.

A space that lasts at least the programmed free time closes the frame. The mark that comes just before that space is a stop pulse and carries no bit. The number of received bits is then checked against a minimum and a maximum frame length, both rounded to even values. A frame that passes publishes its data and its length, and sets a valid flag that software clears. A symbol that fits no window abandons the frame, and the decoder goes back to looking for a new frame.

The timing inputs are meant to come straight from configuration registers. The block keeps its own state only for measurement, framing and the published result.

Top module: `irsym_decoder`

## Requirements
- R1: After reset, rx_valid is 0, rx_len is 0 and both data words are 0.
- R2: When ctl_leader_req is 1, a frame starts only if its first symbol has a width in [wid_min*16, wid_max*16] ticks and a period in [per_min*16, per_max*16] ticks, taken from tmg_leader. A first symbol outside these bounds produces no frame.
- R3: Each data symbol register holds per_max in bits [31:24], per_min in [23:16], wid_max in [15:8] and wid_min in [7:0]. A data symbol matches a register when its width is in [wid_min, wid_max] ticks and its period is in [2*per_min, 2*per_max] ticks. A register whose per_max is 0 is disabled. Registers sym00 and sym10 give bit 0, and sym01 and sym11 give bit 1. When several registers match, the lowest-numbered one decides the bit.
- R4: A data symbol that matches no enabled register abandons the frame, so rx_valid stays 0 for that frame.
- R5: A frame ends when a space reaches cfg_gap*8 ticks. rx_valid does not rise before then. The closing mark does not count as a bit.
- R6: The effective minimum length is cfg_min_len with bit 0 cleared. The effective maximum length is cfg_max_len rounded up to even, capped at 48. A frame whose bit count lies outside [min, max] is dropped and leaves rx_valid at 0.
- R7: With ctl_msb_first at 0, the n-th received bit (counting from 0) lands at data bit n. With ctl_msb_first at 1, each new bit shifts in at bit 0, so the first bit ends up the most significant.
- R8: With ctl_invert_bits at 1, every stored bit is the complement of the decoded bit.
- R9: The mark level is ir_in when ctl_invert_in is 0, and the complement of ir_in when ctl_invert_in is 1.
- R10: When ctl_leader_req is 0, the first mark of a frame already begins a data symbol.
- R11: While ctl_enable is 0, the decoder stays idle and discards any partial frame. A frame sent while it is disabled, or one cut short by disabling, never sets rx_valid.
- R12: A pulse on rx_valid_clr clears rx_valid.
- R13: An accepted frame publishes data bits [31:0] on rx_data_lo, data bits [63:32] on rx_data_hi, and its bit count on rx_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | IR clock enable, one sample per tick |
| ir_in | input | 1 | Demodulated IR line, asynchronous |
| ctl_enable | input | 1 | Decoder enable |
| ctl_invert_in | input | 1 | Treat a low input as mark |
| ctl_msb_first | input | 1 | Bit ordering select |
| ctl_invert_bits | input | 1 | Complement each decoded bit |
| ctl_leader_req | input | 1 | Require a leader symbol |
| tmg_leader | input | 32 | Leader window, fields in units of 16 ticks |
| tmg_sym00 | input | 32 | Data window 0 (bit 0) |
| tmg_sym01 | input | 32 | Data window 1 (bit 1) |
| tmg_sym10 | input | 32 | Data window 2 (bit 0) |
| tmg_sym11 | input | 32 | Data window 3 (bit 1) |
| cfg_gap | input | 12 | Frame-ending space in units of 8 ticks |
| cfg_min_len | input | 5 | Minimum frame length before rounding |
| cfg_max_len | input | 6 | Maximum frame length before rounding |
| rx_valid_clr | input | 1 | Clear pulse for rx_valid |
| rx_data_lo | output | 32 | Received data bits [31:0] |
| rx_data_hi | output | 32 | Received data bits [63:32] |
| rx_len | output | 7 | Received bit count |
| rx_valid | output | 1 | Frame accepted |

## Verification
Frames are built from two timing families: a short and a long space for the primary windows, and wider spaces for the alternate windows, sometimes interleaved in one frame. The recovered words show whether symbols are being sorted by period and routed to the right bit value. Three kinds of damaged frame test whether abandonment really happens: a period that falls between two windows, a mark that is too wide, and a missing or short leader. The bit count is swept across the length gate with both even and odd limits, which exposes off-by-one and rounding errors at the edges. A frame is also checked part-way through its closing gap, to show that the closing mark is not counted and that the result is not published early.

// File: rtl/irsym_pkg.sv
package irsym_pkg;
  localparam int unsigned DATA_W     = 64;
  localparam int unsigned LEN_W      = $clog2(DATA_W + 1);
  localparam int unsigned NUM_SYM    = 4;
  localparam int unsigned LEAD_SHIFT = 4;
  localparam int unsigned PER_SHIFT  = 1;
  localparam int unsigned GAP_SHIFT  = 3;
  localparam int unsigned MAXLEN_CAP = 48;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_DATA = 2'd2
  } irsym_state_e;

  typedef struct packed {
    logic [7:0] per_max;
    logic [7:0] per_min;
    logic [7:0] wid_max;
    logic [7:0] wid_min;
  } sym_win_t;
endpackage

// File: rtl/irsym_sync.sv
module irsym_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ir_in,
  input  logic invert,
  output logic mark,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], ir_in};
  end

  assign mark = sync_q[STAGES-1] ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= 1'b0;
    else if (tick) last_q <= mark;
  end

  assign rise = tick & mark & ~last_q;
endmodule

// File: rtl/irsym_meter.sv
module irsym_meter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             mark,
  input  logic             rise,
  output logic [CNT_W-1:0] wid,
  output logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] spc
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] wid_q, wid_d, per_q, per_d, spc_q, spc_d;

  always_comb begin
    wid_d = wid_q;
    per_d = per_q;
    spc_d = spc_q;
    if (!run) begin
      wid_d = '0;
      per_d = '0;
      spc_d = '0;
    end else if (tick) begin
      if (rise) begin
        wid_d = CNT_ONE;
        per_d = CNT_ONE;
        spc_d = '0;
      end else begin
        if (per_q != CNT_MAX)          per_d = per_q + CNT_ONE;
        if (mark && wid_q != CNT_MAX)  wid_d = wid_q + CNT_ONE;
        if (!mark && spc_q != CNT_MAX) spc_d = spc_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q <= '0;
      per_q <= '0;
      spc_q <= '0;
    end else begin
      wid_q <= wid_d;
      per_q <= per_d;
      spc_q <= spc_d;
    end
  end

  assign wid = wid_q;
  assign per = per_q;
  assign spc = spc_q;

  // R3: a mark can never be longer than the period that contains it
  p_wid_in_per_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wid_q <= per_q);
endmodule

// File: rtl/irsym_classify.sv
module irsym_classify
  import irsym_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0]           wid,
  input  logic [CNT_W-1:0]           per,
  input  sym_win_t                   lead_win,
  input  sym_win_t [NUM_SYM-1:0]     data_win,
  output logic                       lead_hit,
  output logic                       data_hit,
  output logic                       data_bit
);
  function automatic logic in_win(input logic [CNT_W-1:0] v,
                                  input logic [CNT_W-1:0] lo,
                                  input logic [CNT_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic [NUM_SYM-1:0] hit;

  assign lead_hit =
    in_win(wid, CNT_W'(lead_win.wid_min) << LEAD_SHIFT, CNT_W'(lead_win.wid_max) << LEAD_SHIFT) &&
    in_win(per, CNT_W'(lead_win.per_min) << LEAD_SHIFT, CNT_W'(lead_win.per_max) << LEAD_SHIFT);

  for (genvar g = 0; g < NUM_SYM; g++) begin : g_win
    assign hit[g] = (data_win[g].per_max != 8'd0) &&
      in_win(wid, CNT_W'(data_win[g].wid_min), CNT_W'(data_win[g].wid_max)) &&
      in_win(per, CNT_W'(data_win[g].per_min) << PER_SHIFT,
                  CNT_W'(data_win[g].per_max) << PER_SHIFT);
  end

  assign data_hit = |hit;

  always_comb begin
    data_bit = 1'b0;
    for (int i = NUM_SYM - 1; i >= 0; i--) begin
      if (hit[i]) data_bit = i[0];
    end
  end
endmodule

// File: rtl/irsym_decoder.sv
module irsym_decoder
  import irsym_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ir_in,
  input  logic        ctl_enable,
  input  logic        ctl_invert_in,
  input  logic        ctl_msb_first,
  input  logic        ctl_invert_bits,
  input  logic        ctl_leader_req,
  input  logic [31:0] tmg_leader,
  input  logic [31:0] tmg_sym00,
  input  logic [31:0] tmg_sym01,
  input  logic [31:0] tmg_sym10,
  input  logic [31:0] tmg_sym11,
  input  logic [11:0] cfg_gap,
  input  logic [4:0]  cfg_min_len,
  input  logic [5:0]  cfg_max_len,
  input  logic        rx_valid_clr,
  output logic [31:0] rx_data_lo,
  output logic [31:0] rx_data_hi,
  output logic [6:0]  rx_len,
  output logic        rx_valid
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic             mark, rise;
  logic [CNT_W-1:0] wid, per, spc;
  logic             lead_hit, data_hit, data_bit;
  sym_win_t         lead_win;
  sym_win_t [NUM_SYM-1:0] data_win;

  irsym_state_e      st_q, st_d;
  logic [DATA_W-1:0] shift_q, shift_d, data_q;
  logic [LEN_W-1:0]  cnt_q, cnt_d, len_q;
  logic              valid_q, frame_ok, sym_done, bitv;
  logic [LEN_W-1:0]  min_eff, max_eff, max_inc;
  logic [CNT_W-1:0]  gap_ticks;

  assign lead_win = sym_win_t'(tmg_leader);
  assign data_win = {sym_win_t'(tmg_sym11), sym_win_t'(tmg_sym10),
                     sym_win_t'(tmg_sym01), sym_win_t'(tmg_sym00)};

  irsym_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ir_in(ir_in),
    .invert(ctl_invert_in), .mark(mark), .rise(rise)
  );

  irsym_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctl_enable),
    .mark(mark), .rise(rise), .wid(wid), .per(per), .spc(spc)
  );

  irsym_classify #(.CNT_W(CNT_W)) u_class (
    .wid(wid), .per(per), .lead_win(lead_win), .data_win(data_win),
    .lead_hit(lead_hit), .data_hit(data_hit), .data_bit(data_bit)
  );

  // length gate limits, rounded to even
  assign min_eff   = LEN_W'(cfg_min_len) & ~LEN_ONE;
  assign max_inc   = LEN_W'(cfg_max_len) + LEN_ONE;
  assign max_eff   = (cfg_max_len >= 6'(MAXLEN_CAP)) ? LEN_W'(MAXLEN_CAP)
                                                     : (max_inc & ~LEN_ONE);
  assign gap_ticks = CNT_W'(cfg_gap) << GAP_SHIFT;
  assign sym_done  = rise && (st_q != ST_IDLE);
  assign bitv      = data_bit ^ ctl_invert_bits;

  always_comb begin
    st_d     = st_q;
    shift_d  = shift_q;
    cnt_d    = cnt_q;
    frame_ok = 1'b0;
    if (!ctl_enable) begin
      st_d = ST_IDLE;
    end else if (tick) begin
      if (rise) begin
        unique case (st_q)
          ST_IDLE: begin
            st_d    = ctl_leader_req ? ST_LEAD : ST_DATA;
            shift_d = '0;
            cnt_d   = '0;
          end
          ST_LEAD: st_d = lead_hit ? ST_DATA : ST_IDLE;
          ST_DATA: begin
            if (data_hit) begin
              if (ctl_msb_first) begin
                shift_d = {shift_q[DATA_W-2:0], bitv};
              end else if (cnt_q < LEN_W'(DATA_W)) begin
                shift_d[cnt_q[LEN_W-2:0]] = bitv;
              end
              if (cnt_q != LEN_MAX) cnt_d = cnt_q + LEN_ONE;
            end else begin
              st_d = ST_IDLE;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end else if (st_q != ST_IDLE && spc >= gap_ticks) begin
        frame_ok = (st_q == ST_DATA) && (cnt_q >= min_eff) && (cnt_q <= max_eff);
        st_d     = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      len_q   <= '0;
      valid_q <= 1'b0;
    end else if (frame_ok) begin
      data_q  <= shift_q;
      len_q   <= cnt_q;
      valid_q <= 1'b1;
    end else if (rx_valid_clr) begin
      valid_q <= 1'b0;
    end
  end

  assign rx_data_lo = data_q[31:0];
  assign rx_data_hi = data_q[63:32];
  assign rx_len     = len_q;
  assign rx_valid   = valid_q;

  p_leader_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sym_done && ctl_enable && st_q == ST_LEAD && lead_hit) |=> (st_q == ST_DATA));

  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sym_done && ctl_enable && st_q == ST_DATA && !data_hit) |=> (st_q == ST_IDLE));

  p_len_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> (rx_valid && rx_len >= $past(min_eff) && rx_len <= $past(max_eff)));

  p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> (st_q == ST_IDLE));

  p_valid_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_clr && !frame_ok) |=> !rx_valid);
endmodule

// File: tb/tb_irsym_decoder.sv
module tb_irsym_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, tick, ir_in;
  logic        ctl_enable, ctl_invert_in, ctl_msb_first, ctl_invert_bits, ctl_leader_req;
  logic [31:0] tmg_leader, tmg_sym00, tmg_sym01, tmg_sym10, tmg_sym11;
  logic [11:0] cfg_gap;
  logic [4:0]  cfg_min_len;
  logic [5:0]  cfg_max_len;
  logic        rx_valid_clr;
  logic [31:0] rx_data_lo, rx_data_hi;
  logic [6:0]  rx_len;
  logic        rx_valid;

  int checks = 0;
  int errors = 0;
  bit pol    = 1'b0;

  irsym_decoder dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ir_in(ir_in),
    .ctl_enable(ctl_enable), .ctl_invert_in(ctl_invert_in),
    .ctl_msb_first(ctl_msb_first), .ctl_invert_bits(ctl_invert_bits),
    .ctl_leader_req(ctl_leader_req), .tmg_leader(tmg_leader),
    .tmg_sym00(tmg_sym00), .tmg_sym01(tmg_sym01), .tmg_sym10(tmg_sym10),
    .tmg_sym11(tmg_sym11), .cfg_gap(cfg_gap), .cfg_min_len(cfg_min_len),
    .cfg_max_len(cfg_max_len), .rx_valid_clr(rx_valid_clr),
    .rx_data_lo(rx_data_lo), .rx_data_hi(rx_data_hi), .rx_len(rx_len),
    .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial tick = 1'b0;
  always @(negedge clk) tick <= ~tick;

  function automatic logic [31:0] win(input int pmax, input int pmin, input int wmax, input int wmin);
    return {8'(pmax), 8'(pmin), 8'(wmax), 8'(wmin)};
  endfunction

  function automatic logic [63:0] expect_data(input logic [63:0] bits, input int n,
                                               input bit msb, input bit inv);
    logic [63:0] e = '0;
    for (int i = 0; i < n; i++) begin
      if (msb) e = {e[62:0], bits[i] ^ inv};
      else     e[i] = bits[i] ^ inv;
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // hold mark level m for a number of IR ticks (two clocks each)
  task automatic hold(input bit m, input int ticks);
    ir_in = m ^ pol;
    repeat (2 * ticks) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit alt);
    hold(1'b1, 4);
    if (alt) hold(1'b0, b ? 28 : 20);
    else     hold(1'b0, b ? 12 : 4);
  endtask

  // leader (if lead_w > 0), bits, closing mark; no trailing space
  task automatic send_body(input logic [63:0] bits, input int n, input int lead_w,
                           input logic [63:0] altmask);
    if (lead_w > 0) begin
      hold(1'b1, lead_w);
      hold(1'b0, 32);
    end
    for (int i = 0; i < n; i++) send_bit(bits[i], altmask[i]);
    hold(1'b1, 4);
  endtask

  task automatic send_frame(input logic [63:0] bits, input int n, input int lead_w,
                            input logic [63:0] altmask);
    send_body(bits, n, lead_w, altmask);
    hold(1'b0, 60);
  endtask

  task automatic clear_valid();
    rx_valid_clr = 1'b1;
    @(negedge clk);
    rx_valid_clr = 1'b0;
    @(negedge clk);
    chk("R12 valid cleared", 64'(rx_valid), 64'd0);
  endtask

  task automatic check_frame(input string req, input logic [63:0] bits, input int n,
                             input bit msb, input bit inv, input bit accept);
    chk({req, " valid"}, 64'(rx_valid), 64'(accept));
    if (accept) begin
      chk({req, " data"}, {rx_data_hi, rx_data_lo}, expect_data(bits, n, msb, inv));
      chk({req, " length"}, 64'(rx_len), 64'(n));
    end
    clear_valid();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ir_in = 1'b0;
    rx_valid_clr = 1'b0;
    ctl_enable = 1'b1;
    ctl_invert_in = 1'b0;
    ctl_msb_first = 1'b0;
    ctl_invert_bits = 1'b0;
    ctl_leader_req = 1'b1;
    tmg_leader = win(7, 5, 5, 3);
    tmg_sym00  = win(5, 3, 6, 2);
    tmg_sym01  = win(9, 7, 6, 2);
    tmg_sym10  = 32'd0;
    tmg_sym11  = 32'd0;
    cfg_gap     = 12'd5;
    cfg_min_len = 5'd0;
    cfg_max_len = 6'd63;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(rx_valid), 64'd0);
    chk("R1 length", 64'(rx_len), 64'd0);
    chk("R1 data", {rx_data_hi, rx_data_lo}, 64'd0);
    rst_n = 1'b1;
    hold(1'b0, 20);

    // R7 and R13: 40-bit LSB-first frame reaching the upper word
    send_frame(64'h00_A5C3_F01E_96, 40, 64, 64'd0);
    check_frame("R13 R7 lsb", 64'h00_A5C3_F01E_96, 40, 1'b0, 1'b0, 1'b1);

    // R7 MSB-first
    ctl_msb_first = 1'b1;
    send_frame(64'h0000_0000_3C5A_E1B7, 32, 64, 64'd0);
    check_frame("R7 msb", 64'h0000_0000_3C5A_E1B7, 32, 1'b1, 1'b0, 1'b1);
    ctl_msb_first = 1'b0;

    // R8 bit inversion
    ctl_invert_bits = 1'b1;
    send_frame(64'h0000_0000_0096_C3A1, 24, 64, 64'd0);
    check_frame("R8 invert bits", 64'h0000_0000_0096_C3A1, 24, 1'b0, 1'b1, 1'b1);
    ctl_invert_bits = 1'b0;

    // R9 input polarity
    pol = 1'b1;
    ctl_invert_in = 1'b1;
    hold(1'b0, 60);
    clear_valid();
    send_frame(64'h0000_0000_0000_5A3D, 16, 64, 64'd0);
    check_frame("R9 inverted input", 64'h0000_0000_0000_5A3D, 16, 1'b0, 1'b0, 1'b1);
    pol = 1'b0;
    ctl_invert_in = 1'b0;
    hold(1'b0, 60);
    clear_valid();

    // R10 no leader needed
    ctl_leader_req = 1'b0;
    send_frame(64'h0000_0000_0000_B2E7, 16, 0, 64'd0);
    check_frame("R10 no leader", 64'h0000_0000_0000_B2E7, 16, 1'b0, 1'b0, 1'b1);
    ctl_leader_req = 1'b1;

    // R2 missing leader, then short leader
    send_frame(64'h0000_0000_0000_B2E7, 16, 0, 64'd0);
    check_frame("R2 missing leader", 64'h0, 16, 1'b0, 1'b0, 1'b0);
    send_frame(64'h0000_0000_0000_B2E7, 16, 32, 64'd0);
    check_frame("R2 short leader", 64'h0, 16, 1'b0, 1'b0, 1'b0);

    // R4 period between windows mid-frame
    send_body(64'h15, 5, 64, 64'd0);
    hold(1'b1, 4); hold(1'b0, 8);
    for (int i = 0; i < 5; i++) send_bit(i[0], 1'b0);
    hold(1'b1, 4); hold(1'b0, 60);
    check_frame("R4 bad period", 64'h0, 11, 1'b0, 1'b0, 1'b0);
    // R4 mark too wide
    send_body(64'h0A, 5, 64, 64'd0);
    hold(1'b1, 10); hold(1'b0, 6);
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    hold(1'b1, 4); hold(1'b0, 60);
    check_frame("R4 bad width", 64'h0, 11, 1'b0, 1'b0, 1'b0);

    // R3 alternate windows disabled by zero per_max
    send_frame(64'h0000_0000_000A_5C33, 20, 64, 64'h0000_0000_000F_FFFF);
    check_frame("R3 disabled windows", 64'h0, 20, 1'b0, 1'b0, 1'b0);
    // R3 alternate windows enabled, mixed with primary ones
    tmg_sym10 = win(13, 11, 6, 2);
    tmg_sym11 = win(17, 15, 6, 2);
    send_frame(64'h0000_0000_000A_5C33, 20, 64, 64'h0000_0000_000A_AAAA);
    check_frame("R3 mixed windows", 64'h0000_0000_000A_5C33, 20, 1'b0, 1'b0, 1'b1);
    // R3 overlap: sym10 matches the same period as sym01, lower index wins
    tmg_sym10 = win(9, 7, 6, 2);
    send_frame(64'h0000_0000_0000_00FF, 8, 64, 64'd0);
    check_frame("R3 priority", 64'h0000_0000_0000_00FF, 8, 1'b0, 1'b0, 1'b1);
    tmg_sym10 = 32'd0;
    tmg_sym11 = 32'd0;

    // R5 not published before the gap; closing mark not counted
    send_body(64'h0000_0000_0000_0C69, 12, 64, 64'd0);
    hold(1'b0, 30);
    chk("R5 early", 64'(rx_valid), 64'd0);
    hold(1'b0, 30);
    check_frame("R5 gap end", 64'h0000_0000_0000_0C69, 12, 1'b0, 1'b0, 1'b1);

    // R6 sweep of the length gate: min 8, max 15 -> 16
    cfg_min_len = 5'd8;
    cfg_max_len = 6'd15;
    for (int n = 4; n <= 20; n++) begin
      send_frame(64'h0000_0000_000D_3B6A, n, 64, 64'd0);
      check_frame("R6 sweep", 64'h0000_0000_000D_3B6A, n, 1'b0, 1'b0, (n >= 8) && (n <= 16));
    end
    // R6 odd minimum rounds down, maximum caps at 48
    cfg_min_len = 5'd9;
    cfg_max_len = 6'd63;
    send_frame(64'h0000_0000_0000_005B, 7, 64, 64'd0);
    check_frame("R6 below odd min", 64'h0, 7, 1'b0, 1'b0, 1'b0);
    send_frame(64'h0000_0000_0000_005B, 8, 64, 64'd0);
    check_frame("R6 odd min rounded", 64'h0000_0000_0000_005B, 8, 1'b0, 1'b0, 1'b1);
    send_frame(64'h0001_F00D_CAFE_1234, 48, 64, 64'd0);
    check_frame("R6 at cap", 64'h0000_F00D_CAFE_1234, 48, 1'b0, 1'b0, 1'b1);
    send_frame(64'h0001_F00D_CAFE_1234, 49, 64, 64'd0);
    check_frame("R6 above cap", 64'h0, 49, 1'b0, 1'b0, 1'b0);
    cfg_min_len = 5'd0;

    // R11 disable mid-frame discards the partial frame
    send_body(64'h0000_0000_0000_02D5, 10, 64, 64'd0);
    hold(1'b0, 4);
    ctl_enable = 1'b0;
    repeat (20) @(negedge clk);
    ctl_enable = 1'b1;
    hold(1'b0, 60);
    chk("R11 partial discarded", 64'(rx_valid), 64'd0);
    // R11 frame while disabled
    ctl_enable = 1'b0;
    send_frame(64'h0000_0000_0000_02D5, 10, 64, 64'd0);
    chk("R11 disabled frame", 64'(rx_valid), 64'd0);
    ctl_enable = 1'b1;
    hold(1'b0, 20);
    send_frame(64'h0000_0000_0000_02D5, 10, 64, 64'd0);
    check_frame("R11 re-enabled", 64'h0000_0000_0000_02D5, 10, 1'b0, 1'b0, 1'b1);

    summary();
    $finish;
  end
endmodule